// File: doc/BRIEF.md
# Ping-Pong Period Descriptor Sequencer

This block lets a chained DMA engine run over a circular audio buffer made of N equal periods while holding only two link descriptors. Configuration is loaded with a single `cfg_load` pulse. The block then checks the configuration and emits two setup writes that aim descriptor 0 and descriptor 1 at the first two periods.

Each time the engine reports a finished segment, the block pulses `period_tick`. It also issues one write command that moves the memory-side address of the descriptor that just finished two periods ahead. That target wraps to the buffer base at the buffer end. When the buffer holds exactly two periods, no write is needed and none is issued.

The same configuration produces several side outputs:
- the peripheral-side register address, shifted to the byte lane that matches the sample width;
- the transfer-size code;
- the burst chunk;
- the stream position in frames, derived from the engine's current memory address.

Descriptor writes leave through a valid/ready stream. A command stays on `dw_valid` with stable fields until `dw_ready` takes it. A new segment-done replaces a command that has not yet been taken, and raises the overrun flag.

Top module: `pp_desc_seq`

## Requirements
- R1: `cfg_err` is 1 after reset and after any load whose sample width is not 8, 16 or 32, whose period count is below 2, whose period is below MIN_PERIOD (512) bytes, or whose buffer size is not period count × period size. While `cfg_err` is 1, `seg_done` produces neither `period_tick` nor a write.
- R2: After a valid load, exactly two setup writes appear in this order: index 0 with address base, then index 1 with address base+period. `dw_count` equals the period size.
- R3: With more than two periods, each `seg_done` issues one write. The address sequence starts at base+2×period, grows by one period per event, and wraps to base when it reaches or passes base+buffer size. The first address also wraps this way. `dw_idx` alternates 0,1,0,… starting at 0, and every address lies inside the buffer.
- R4: With exactly two periods, `seg_done` issues no write.
- R5: `period_tick` is a one-cycle pulse in the cycle after each accepted `seg_done`.
- R6: `dw_to_dst` is 0 (source field) for playback and 1 (destination field) for capture.
- R7: `periph_addr` is the peripheral base plus 3 for 8-bit samples, plus 2 for 16-bit samples, and plus 0 for 32-bit samples.
- R8: `xfer_code` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. The frame size is (sample bytes) << `cfg_chan_log2`. `bw_chunk` is two frames for playback and one frame for capture.
- R9: `pos_frames` = (`cur_addr` − base) / frame size, except that a result equal to the buffer length in frames reads 0.
- R10: A `seg_done` arriving while a write is valid and not accepted sets `overrun`, which stays set until the next load. The new write replaces the old one.
- R11: While `dw_valid` is 1 and `dw_ready` is 0, the command holds its index and address until taken, replaced by `seg_done`, or cancelled by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Latch configuration and restart the sequence |
| cfg_base | input | AW | Buffer base address |
| cfg_buf_bytes | input | AW | Buffer size in bytes |
| cfg_period_bytes | input | AW | Period size in bytes |
| cfg_periods | input | PW | Number of periods |
| cfg_capture | input | 1 | 1 = capture, 0 = playback |
| cfg_sample_bits | input | 6 | Sample width in bits |
| cfg_chan_log2 | input | 2 | log2 of channels per frame |
| cfg_periph_base | input | AW | Peripheral data register address |
| cfg_err | output | 1 | Latched configuration is unusable |
| xfer_code | output | 2 | Transfer-size code |
| bw_chunk | output | 8 | Burst chunk in bytes |
| periph_addr | output | AW | Lane-adjusted peripheral address |
| seg_done | input | 1 | Engine finished a segment |
| period_tick | output | 1 | One period elapsed |
| dw_valid | output | 1 | Descriptor write command valid |
| dw_ready | input | 1 | Descriptor write accepted |
| dw_idx | output | 1 | Descriptor index to write |
| dw_to_dst | output | 1 | Field select: 1 destination, 0 source |
| dw_addr | output | AW | Memory address to write |
| dw_count | output | AW | Byte count for the descriptor |
| cur_addr | input | AW | Engine's current memory address |
| pos_frames | output | AW | Stream position in frames |
| overrun | output | 1 | Write was still pending at a segment-done |

## Verification
The checks assume that `seg_done` does not arrive during the two setup writes, because a real engine cannot finish a segment before it has started. They also assume that `cur_addr` stays between base and base+buffer size. The bench issues segment events only after both setup writes have been taken, and only drives positions inside the buffer. The back-pressure properties exclude cycles that carry a load or a segment-done, since those legally cancel or replace the pending command.

// File: rtl/pp_desc_pkg.sv
package pp_desc_pkg;
  localparam int LINKS = 2;
  typedef enum logic [1:0] {
    XF_1B = 2'd0,
    XF_2B = 2'd1,
    XF_4B = 2'd2
  } xfer_e;
endpackage

// File: rtl/pp_cfg_decode.sv
module pp_cfg_decode
  import pp_desc_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int MIN_PERIOD = 512
) (
  input  logic [5:0]    sample_bits,
  input  logic [1:0]    chan_log2,
  input  logic          capture,
  input  logic [PW-1:0] periods,
  input  logic [AW-1:0] period,
  input  logic [AW-1:0] buf_bytes,
  output logic          ok,
  output xfer_e         xfer_code,
  output logic [1:0]    lane_off,
  output logic [2:0]    frame_shift,
  output logic [7:0]    bw_chunk
);
  logic          width_ok;
  logic [1:0]    size_log2;
  logic [AW-1:0] product;

  always_comb begin
    width_ok  = 1'b1;
    size_log2 = 2'd0;
    lane_off  = 2'd0;
    xfer_code = XF_1B;
    case (sample_bits)
      6'd8:  begin xfer_code = XF_1B; lane_off = 2'd3; size_log2 = 2'd0; end
      6'd16: begin xfer_code = XF_2B; lane_off = 2'd2; size_log2 = 2'd1; end
      6'd32: begin xfer_code = XF_4B; lane_off = 2'd0; size_log2 = 2'd2; end
      default: width_ok = 1'b0;
    endcase
  end

  assign product     = AW'(periods) * period;
  assign ok          = width_ok && (periods >= PW'(LINKS)) &&
                       (period >= AW'(MIN_PERIOD)) && (product == buf_bytes);
  assign frame_shift = {1'b0, size_log2} + {1'b0, chan_log2};
  assign bw_chunk    = (capture ? 8'd1 : 8'd2) << frame_shift;
endmodule

// File: rtl/pp_ptr_track.sv
module pp_ptr_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] buf_end,
  input  logic [AW-1:0] period,
  input  logic          two_mode,
  input  logic          seg_done,
  input  logic          dw_ready,
  output logic          dw_valid,
  output logic          dw_idx,
  output logic [AW-1:0] dw_addr,
  output logic          tick,
  output logic          overrun
);
  logic          active, init, idx;
  logic [AW-1:0] next_ptr, ahead, wrapped, first;

  assign ahead   = next_ptr + period;
  assign wrapped = (ahead >= buf_end) ? base : ahead;
  assign first   = ((base + (period << 1)) >= buf_end) ? base : base + (period << 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; init <= 1'b0; idx <= 1'b0;
      dw_valid <= 1'b0; dw_idx <= 1'b0; dw_addr <= '0;
      next_ptr <= '0; tick <= 1'b0; overrun <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (halt) begin
        active <= 1'b0; init <= 1'b0; dw_valid <= 1'b0; overrun <= 1'b0;
      end else if (start) begin
        active <= 1'b1; init <= 1'b1; idx <= 1'b0;
        dw_valid <= 1'b1; dw_idx <= 1'b0; dw_addr <= base;
        next_ptr <= first;
      end else begin
        if (dw_valid && dw_ready) begin
          if (init && !dw_idx) begin
            dw_idx  <= 1'b1;
            dw_addr <= base + period;
          end else begin
            dw_valid <= 1'b0;
            init     <= 1'b0;
          end
        end
        if (seg_done && active) begin
          tick <= 1'b1;
          if (dw_valid && !dw_ready) overrun <= 1'b1;
          if (!two_mode) begin
            dw_valid <= 1'b1; dw_idx <= idx; dw_addr <= next_ptr;
            next_ptr <= wrapped; idx <= ~idx; init <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pp_pos_calc.sv
module pp_pos_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] buf_bytes,
  input  logic [2:0]    frame_shift,
  output logic [AW-1:0] pos_frames
);
  logic [AW-1:0] raw, total;
  assign raw        = (cur_addr - base) >> frame_shift;
  assign total      = buf_bytes >> frame_shift;
  assign pos_frames = (raw == total) ? '0 : raw;
endmodule

// File: rtl/pp_desc_seq.sv
module pp_desc_seq
  import pp_desc_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 16,
  parameter int MIN_PERIOD = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_buf_bytes,
  input  logic [AW-1:0] cfg_period_bytes,
  input  logic [PW-1:0] cfg_periods,
  input  logic          cfg_capture,
  input  logic [5:0]    cfg_sample_bits,
  input  logic [1:0]    cfg_chan_log2,
  input  logic [AW-1:0] cfg_periph_base,
  output logic          cfg_err,
  output logic [1:0]    xfer_code,
  output logic [7:0]    bw_chunk,
  output logic [AW-1:0] periph_addr,
  input  logic          seg_done,
  output logic          period_tick,
  output logic          dw_valid,
  input  logic          dw_ready,
  output logic          dw_idx,
  output logic          dw_to_dst,
  output logic [AW-1:0] dw_addr,
  output logic [AW-1:0] dw_count,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] pos_frames,
  output logic          overrun
);
  logic [AW-1:0] base_r, buf_r, end_r, period_r, periph_r;
  logic [PW-1:0] periods_r;
  logic          cap_r, load_q, cfg_ok, two_mode;
  logic [5:0]    sbits_r;
  logic [1:0]    chan_r, lane_off;
  logic [2:0]    frame_shift;
  xfer_e         code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_r <= '0; buf_r <= '0; end_r <= '0; period_r <= '0; periph_r <= '0;
      periods_r <= '0; cap_r <= 1'b0; sbits_r <= '0; chan_r <= '0; load_q <= 1'b0;
    end else begin
      load_q <= cfg_load;
      if (cfg_load) begin
        base_r    <= cfg_base;
        buf_r     <= cfg_buf_bytes;
        end_r     <= cfg_base + cfg_buf_bytes;
        period_r  <= cfg_period_bytes;
        periods_r <= cfg_periods;
        cap_r     <= cfg_capture;
        sbits_r   <= cfg_sample_bits;
        chan_r    <= cfg_chan_log2;
        periph_r  <= cfg_periph_base;
      end
    end
  end

  pp_cfg_decode #(.AW(AW), .PW(PW), .MIN_PERIOD(MIN_PERIOD)) dec_i (
    .sample_bits(sbits_r), .chan_log2(chan_r), .capture(cap_r),
    .periods(periods_r), .period(period_r), .buf_bytes(buf_r),
    .ok(cfg_ok), .xfer_code(code), .lane_off(lane_off),
    .frame_shift(frame_shift), .bw_chunk(bw_chunk)
  );

  assign two_mode = (periods_r == PW'(LINKS));

  pp_ptr_track #(.AW(AW)) trk_i (
    .clk(clk), .rst_n(rst_n), .halt(cfg_load), .start(load_q && cfg_ok),
    .base(base_r), .buf_end(end_r), .period(period_r), .two_mode(two_mode),
    .seg_done(seg_done), .dw_ready(dw_ready), .dw_valid(dw_valid),
    .dw_idx(dw_idx), .dw_addr(dw_addr), .tick(period_tick), .overrun(overrun)
  );

  pp_pos_calc #(.AW(AW)) pos_i (
    .cur_addr(cur_addr), .base(base_r), .buf_bytes(buf_r),
    .frame_shift(frame_shift), .pos_frames(pos_frames)
  );

  assign cfg_err     = !cfg_ok;
  assign xfer_code   = code;
  assign periph_addr = periph_r + AW'(lane_off);
  assign dw_to_dst   = cap_r;
  assign dw_count    = period_r;
endmodule

// File: rtl/pp_desc_seq_chk.sv
module pp_desc_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          load_q,
  input logic          seg_done,
  input logic          dw_valid,
  input logic          dw_ready,
  input logic          dw_idx,
  input logic [AW-1:0] dw_addr,
  input logic          period_tick,
  input logic          overrun,
  input logic          two_mode,
  input logic [AW-1:0] base_r,
  input logic [AW-1:0] end_r
);
  p_addr_in_buf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> (dw_addr >= base_r && dw_addr < end_r));

  p_no_rewrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_done && !dw_valid && two_mode && !cfg_load && !load_q) |=> !dw_valid);

  p_tick_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |-> $past(seg_done));

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(seg_done && dw_valid && !dw_ready));

  p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !dw_ready && !seg_done && !cfg_load) |=>
      (dw_valid && $stable(dw_addr) && $stable(dw_idx)));
endmodule

bind pp_desc_seq pp_desc_seq_chk #(.AW(AW)) chk_i (.*);

// File: tb/pp_desc_seq_tb_top.sv
module pp_desc_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_load = 1'b0, cfg_capture = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_buf_bytes = '0, cfg_period_bytes = '0, cfg_periph_base = '0;
  logic [PW-1:0] cfg_periods = '0;
  logic [5:0]    cfg_sample_bits = '0;
  logic [1:0]    cfg_chan_log2 = '0;
  logic          seg_done = 1'b0, dw_ready = 1'b1;
  logic [AW-1:0] cur_addr = '0;
  logic          cfg_err, period_tick, dw_valid, dw_idx, dw_to_dst, overrun;
  logic [1:0]    xfer_code;
  logic [7:0]    bw_chunk;
  logic [AW-1:0] periph_addr, dw_addr, dw_count, pos_frames;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_desc_seq dut_i (.*);

  typedef struct packed {
    logic [5:0] sb; logic [1:0] cl; logic cap; logic err;
    logic [1:0] code; logic [1:0] off; logic [7:0] bw;
  } vec_t;
  localparam vec_t VECS [9] = '{
    '{6'd8,  2'd0, 1'b0, 1'b0, 2'd0, 2'd3, 8'd2},
    '{6'd8,  2'd1, 1'b1, 1'b0, 2'd0, 2'd3, 8'd2},
    '{6'd16, 2'd0, 1'b0, 1'b0, 2'd1, 2'd2, 8'd4},
    '{6'd16, 2'd2, 1'b1, 1'b0, 2'd1, 2'd2, 8'd8},
    '{6'd32, 2'd0, 1'b0, 1'b0, 2'd2, 2'd0, 8'd8},
    '{6'd32, 2'd3, 1'b1, 1'b0, 2'd2, 2'd0, 8'd32},
    '{6'd32, 2'd3, 1'b0, 1'b0, 2'd2, 2'd0, 8'd64},
    '{6'd24, 2'd0, 1'b0, 1'b1, 2'd0, 2'd0, 8'd0},
    '{6'd0,  2'd0, 1'b0, 1'b1, 2'd0, 2'd0, 8'd0}
  };

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] b, input logic [AW-1:0] bsz, input logic [AW-1:0] p,
                      input logic [PW-1:0] n, input logic cap, input logic [5:0] sb, input logic [1:0] cl);
    @(negedge clk);
    cfg_base = b; cfg_buf_bytes = bsz; cfg_period_bytes = p; cfg_periods = n;
    cfg_capture = cap; cfg_sample_bits = sb; cfg_chan_log2 = cl; cfg_periph_base = 32'h8000;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic expect_write(input logic idx, input logic [AW-1:0] addr, input string tag);
    for (int n = 0; n < 6 && !dw_valid; n++) @(negedge clk);
    check(dw_valid === 1'b1, tag, AW'(dw_valid), 1);
    check(dw_idx === idx, tag, AW'(dw_idx), AW'(idx));
    check(dw_addr === addr, tag, dw_addr, addr);
    @(negedge clk);
  endtask

  task automatic pulse_seg;
    @(negedge clk); seg_done = 1'b1;
    @(negedge clk); seg_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_err === 1'b1, "R1 reset err", AW'(cfg_err), 1);
    check(dw_valid === 1'b0 && period_tick === 1'b0 && overrun === 1'b0, "R5 reset idle", AW'(dw_valid), 0);

    // R7 R8 table
    foreach (VECS[i]) begin
      load(32'h1000, 32'h800, 32'h200, 16'd4, VECS[i].cap, VECS[i].sb, VECS[i].cl);
      check(cfg_err === VECS[i].err, "R1 table err", AW'(cfg_err), AW'(VECS[i].err));
      if (!VECS[i].err) begin
        check(xfer_code === VECS[i].code, "R8 code", AW'(xfer_code), AW'(VECS[i].code));
        check(bw_chunk === VECS[i].bw, "R8 bw", AW'(bw_chunk), AW'(VECS[i].bw));
        check(periph_addr === 32'h8000 + AW'(VECS[i].off), "R7 periph", periph_addr, 32'h8000 + AW'(VECS[i].off));
        check(dw_to_dst === VECS[i].cap, "R6 field", AW'(dw_to_dst), AW'(VECS[i].cap));
      end
      repeat (4) @(negedge clk);
    end

    // R2 R3 six periods playback, 16-bit stereo
    load(32'h1000, 32'hC00, 32'h200, 16'd6, 1'b0, 6'd16, 2'd1);
    expect_write(1'b0, 32'h1000, "R2 init0");
    check(dw_count === 32'h200, "R2 count", dw_count, 32'h200);
    expect_write(1'b1, 32'h1200, "R2 init1");
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] ea;
      ea = 32'h1000 + AW'(((k + 2) % 6) * 32'h200);
      pulse_seg();
      check(period_tick === 1'b1, "R5 tick", AW'(period_tick), 1);
      expect_write(1'(k & 1), ea, "R3 rewrite");
    end
    check(period_tick === 1'b0, "R5 single pulse", AW'(period_tick), 0);

    // R9 position, frame 4 bytes
    cur_addr = 32'h1000; #1; check(pos_frames === 0, "R9 zero", pos_frames, 0);
    cur_addr = 32'h1010; #1; check(pos_frames === 4, "R9 mid", pos_frames, 4);
    cur_addr = 32'h1BFC; #1; check(pos_frames === 32'h2FF, "R9 last", pos_frames, 32'h2FF);
    cur_addr = 32'h1C00; #1; check(pos_frames === 0, "R9 end wraps", pos_frames, 0);

    // R10 R11 back-pressure
    dw_ready = 1'b0;
    pulse_seg();
    repeat (2) @(negedge clk);
    check(dw_valid === 1'b1 && dw_addr === 32'h1400 && dw_idx === 1'b0, "R11 hold", dw_addr, 32'h1400);
    check(overrun === 1'b0, "R10 no overrun yet", AW'(overrun), 0);
    pulse_seg();
    check(overrun === 1'b1, "R10 overrun", AW'(overrun), 1);
    check(dw_addr === 32'h1600 && dw_idx === 1'b1, "R10 replace", dw_addr, 32'h1600);
    dw_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(dw_valid === 1'b0, "R11 taken", AW'(dw_valid), 0);

    // R6 R3 capture, three periods, 8-bit mono: first ahead wraps after one step
    load(32'h2000, 32'h600, 32'h200, 16'd3, 1'b1, 6'd8, 2'd0);
    check(overrun === 1'b0, "R10 cleared by load", AW'(overrun), 0);
    check(dw_to_dst === 1'b1, "R6 capture dst", AW'(dw_to_dst), 1);
    expect_write(1'b0, 32'h2000, "R2 cap init0");
    expect_write(1'b1, 32'h2200, "R2 cap init1");
    pulse_seg(); expect_write(1'b0, 32'h2400, "R3 cap first");
    pulse_seg(); expect_write(1'b1, 32'h2000, "R3 cap wrap");

    // R4 two periods
    load(32'h3000, 32'h400, 32'h200, 16'd2, 1'b0, 6'd32, 2'd0);
    expect_write(1'b0, 32'h3000, "R4 init0");
    expect_write(1'b1, 32'h3200, "R4 init1");
    pulse_seg();
    check(period_tick === 1'b1, "R4 tick", AW'(period_tick), 1);
    check(dw_valid === 1'b0, "R4 no write", AW'(dw_valid), 0);
    @(negedge clk);
    check(dw_valid === 1'b0, "R4 still none", AW'(dw_valid), 0);

    // R1 invalid configurations ignore seg_done
    load(32'h3000, 32'h200, 32'h200, 16'd1, 1'b0, 6'd16, 2'd0);
    check(cfg_err === 1'b1, "R1 one period", AW'(cfg_err), 1);
    @(negedge clk);
    check(dw_valid === 1'b0, "R1 no init write", AW'(dw_valid), 0);
    pulse_seg();
    check(period_tick === 1'b0 && dw_valid === 1'b0, "R1 seg ignored", AW'(period_tick), 0);
    load(32'h3000, 32'h200, 32'h100, 16'd2, 1'b0, 6'd16, 2'd0);
    check(cfg_err === 1'b1, "R1 short period", AW'(cfg_err), 1);
    load(32'h3000, 32'h500, 32'h200, 16'd2, 1'b0, 6'd16, 2'd0);
    check(cfg_err === 1'b1, "R1 size mismatch", AW'(cfg_err), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule